// File: doc/BRIEF.md
# SMBus Indexed Block Register Target

This block is a serial-bus target that gives a host access to a bank of sixteen 8-bit configuration registers over a two-wire SMBus/I2C link. It filters and synchronises the clock and data lines. It finds start, repeated-start and stop conditions and matches one fixed 7-bit device address. The address-select input chooses which of two addresses applies.

A write names a starting register index and then a byte count, and then delivers that many data bytes into consecutive registers. A read first sets the index with a short write. It follows with a repeated start and the read address. The target then sends a count byte before any data. That count byte is whatever the count register (index 8) holds, so the host controls how long reads are meant to be. The index pointer advances after every data byte and wraps around the bank.

The data line is driven open-drain: the block only ever pulls it low, through an output enable.

Top module: `smb_regbank_target`

## Requirements
- R1: With `addr_sel_i` low, the target acknowledges the address bytes 0xDC (write) and 0xDD (read), i.e. 7-bit 0x6E. With `addr_sel_i` high it answers only 7-bit 0x6F (bytes 0xDE/0xDF). Any other address is not acknowledged and the rest of that transaction is ignored.
- R2: A block write is sent as address, index N, count X, then X data bytes. It stores the data bytes in registers N, N+1, ... N+X-1. Each of these bytes, the address byte included, receives an acknowledge (SDA held low in the ninth clock).
- R3: The register index wraps from 15 back to 0, for both writes and reads.
- R4: A block read is sent as a write of index N, then a repeated start, then the read address. The target sends the count byte first and then registers N, N+1, ... in turn, MSB first.
- R5: The count byte sent on a read is the current content of register 8. Register 8 is writable and resets to 0x08.
- R6: Register 14 is reserved and reads 0x00. Register 15 is read-only and reads 0xA5. Writes to either are acknowledged and discarded, and the index still advances.
- R7: Data bytes sent after the announced count is used up are not acknowledged and do not change any register.
- R8: After the host answers a sent byte with a not-acknowledge, the target leaves SDA released until the next start or stop.
- R9: A stop ends the transaction and releases SDA. A partly received byte is dropped, while bytes already completed stay written. A start at any point restarts address reception.
- R10: The target changes its SDA drive only while SCL is low, and it samples incoming bits on rising SCL.
- R11: After reset SDA is released. Registers 0 to 13 read 0x00, register 8 reads 0x08 and register 15 reads 0xA5.
- R12: A pulse on SCL shorter than the filter length (FILT_LEN clocks, default 3) is ignored and does not disturb a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| addr_sel_i | input | 1 | Selects the alternate 7-bit device address when high |
| sda_oe_o | output | 1 | Pull SDA low when 1, release when 0 |

## Verification
The two functions that can meet are the bit engine and condition detection. A stop may arrive while the receiver sits in the middle of a data byte, and it must win over byte completion. The bench provokes this by ending a write four bits into its second data byte. It judges the outcome by reading the bank back: the first data byte must be present and the target register of the partial byte must be unchanged. A second meeting is the host NACK and the next transmit load. Here the bench clocks an extra bit after the NACK and checks that the line stays high.

// File: rtl/smb_tgt_pkg.sv
package smb_tgt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RACK,
    ST_TX,
    ST_TACK,
    ST_WAIT
  } tgt_state_e;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_IDX,
    PH_CNT,
    PH_DATA
  } rx_phase_e;

  // pointer step with wrap over the bank size
  function automatic int unsigned next_index(input int unsigned idx, input int unsigned n);
    return (idx + 1) % n;
  endfunction

  // 7-bit address compare with alternate selection
  function automatic logic addr_hit(input logic [6:0] a7, input logic sel,
                                    input logic [6:0] base, input logic [6:0] alt);
    return a7 == (sel ? alt : base);
  endfunction

  // locations that hold storage
  function automatic logic is_writable(input int unsigned idx, input int unsigned ro_a,
                                       input int unsigned ro_b);
    return (idx != ro_a) && (idx != ro_b);
  endfunction

endpackage

// File: rtl/smb_line_filter.sv
module smb_line_filter #(
  parameter int FILT_LEN = 3,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic filt_o
);
  localparam int CNT_W = $clog2(FILT_LEN + 1);

  logic [1:0]       sync_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= {2{RST_VAL}};
      cnt_q  <= '0;
      filt_o <= RST_VAL;
    end else begin
      sync_q <= {sync_q[0], line_i};
      if (sync_q[1] == filt_o) begin
        cnt_q <= '0;
      end else if (cnt_q == CNT_W'(FILT_LEN - 1)) begin
        filt_o <= sync_q[1];
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/smb_bus_events.sv
module smb_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic ev_start,
  output logic ev_stop
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise = scl_f & ~scl_q;
  assign scl_fall = ~scl_f & scl_q;
  assign ev_start = scl_f & scl_q & sda_q & ~sda_f;
  assign ev_stop  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank #(
  parameter int          N_REGS  = 16,
  parameter int          DW      = 8,
  parameter int          CNT_IDX = 8,
  parameter int          ID_IDX  = 15,
  parameter int          RSV_IDX = 14,
  parameter logic [7:0]  ID_VAL  = 8'hA5,
  parameter logic [7:0]  CNT_RST = 8'h08,
  localparam int         AW      = $clog2(N_REGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] cnt_o
);
  logic [N_REGS*DW-1:0] flat;

  for (genvar g = 0; g < N_REGS; g++) begin : g_cell
    if (g == ID_IDX) begin : g_id
      assign flat[g*DW +: DW] = DW'(ID_VAL);
    end else if (g == RSV_IDX) begin : g_rsv
      assign flat[g*DW +: DW] = '0;
    end else begin : g_rw
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          q <= (g == CNT_IDX) ? DW'(CNT_RST) : '0;
        else if (we && (waddr == AW'(g)))
          q <= wdata;
      end
      assign flat[g*DW +: DW] = q;
    end
  end

  assign rdata = flat[raddr*DW +: DW];
  assign cnt_o = flat[CNT_IDX*DW +: DW];
endmodule

// File: rtl/smb_regbank_target.sv
module smb_regbank_target
  import smb_tgt_pkg::*;
#(
  parameter int         FILT_LEN  = 3,
  parameter int         N_REGS    = 16,
  parameter int         CNT_IDX   = 8,
  parameter int         ID_IDX    = 15,
  parameter int         RSV_IDX   = 14,
  parameter logic [7:0] ID_VAL    = 8'hA5,
  parameter logic [7:0] CNT_RST   = 8'h08,
  parameter logic [6:0] ADDR_BASE = 7'h6E,
  parameter logic [6:0] ADDR_ALT  = 7'h6F
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic addr_sel_i,
  output logic sda_oe_o
);
  localparam int AW     = $clog2(N_REGS);
  localparam int BYTE_W = 8;
  localparam int N_LINE = 2;

  // ---- line conditioning ----
  logic [N_LINE-1:0] line_raw, line_f;
  assign line_raw = {sda_i, scl_i};

  for (genvar l = 0; l < N_LINE; l++) begin : g_filt
    smb_line_filter #(.FILT_LEN(FILT_LEN), .RST_VAL(1'b1)) u_filt (
      .clk(clk), .rst_n(rst_n), .line_i(line_raw[l]), .filt_o(line_f[l])
    );
  end

  logic scl_f, sda_f;
  assign scl_f = line_f[0];
  assign sda_f = line_f[1];

  // ---- bus events, named for the checker ----
  logic scl_rise, scl_fall, ev_start, ev_stop;
  smb_bus_events u_evt (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .ev_start(ev_start), .ev_stop(ev_stop)
  );

  // ---- state ----
  tgt_state_e        state;
  rx_phase_e         phase;
  logic [3:0]        bitcnt;
  logic [6:0]        rx_sh;
  logic [BYTE_W-1:0] tx_sh;
  logic [AW-1:0]     ptr;
  logic [BYTE_W-1:0] remain;
  logic              ack_q, go_tx, miss_q, sda_oe;

  logic [BYTE_W-1:0] rx_byte, rd_data, cnt_val;
  logic              rx_done, wr_stb, reg_we;
  logic [AW-1:0]     ptr_nxt;

  assign rx_byte = {rx_sh, sda_f};
  assign rx_done = (state == ST_RX) && scl_rise && (bitcnt == 4'd7);
  assign wr_stb  = rx_done && (phase == PH_DATA) && (remain != '0);
  assign reg_we  = wr_stb && is_writable({{(32-AW){1'b0}}, ptr}, ID_IDX, RSV_IDX);
  assign ptr_nxt = AW'(next_index({{(32-AW){1'b0}}, ptr}, N_REGS));

  smb_reg_bank #(
    .N_REGS(N_REGS), .DW(BYTE_W), .CNT_IDX(CNT_IDX), .ID_IDX(ID_IDX),
    .RSV_IDX(RSV_IDX), .ID_VAL(ID_VAL), .CNT_RST(CNT_RST)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .waddr(ptr), .wdata(rx_byte),
    .raddr(ptr), .rdata(rd_data), .cnt_o(cnt_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      phase  <= PH_ADDR;
      bitcnt <= '0;
      rx_sh  <= '0;
      tx_sh  <= '0;
      ptr    <= '0;
      remain <= '0;
      ack_q  <= 1'b0;
      go_tx  <= 1'b0;
      miss_q <= 1'b0;
      sda_oe <= 1'b0;
    end else if (ev_stop) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else if (ev_start) begin
      state  <= ST_RX;
      phase  <= PH_ADDR;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else begin
      unique case (state)
        ST_RX: begin
          if (scl_rise) begin
            rx_sh  <= rx_byte[6:0];
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == 4'd7) begin
              unique case (phase)
                PH_ADDR: begin
                  if (addr_hit(rx_byte[7:1], addr_sel_i, ADDR_BASE, ADDR_ALT)) begin
                    ack_q  <= 1'b1;
                    miss_q <= 1'b0;
                    go_tx  <= rx_byte[0];
                    phase  <= PH_IDX;
                  end else begin
                    ack_q  <= 1'b0;
                    miss_q <= 1'b1;
                    go_tx  <= 1'b0;
                  end
                end
                PH_IDX: begin
                  ptr   <= rx_byte[AW-1:0];
                  phase <= PH_CNT;
                  ack_q <= 1'b1;
                  go_tx <= 1'b0;
                end
                PH_CNT: begin
                  remain <= rx_byte;
                  phase  <= PH_DATA;
                  ack_q  <= 1'b1;
                end
                PH_DATA: begin
                  if (remain != '0) begin
                    ptr    <= ptr_nxt;
                    remain <= remain - 1'b1;
                    ack_q  <= 1'b1;
                  end else begin
                    ack_q  <= 1'b0;
                  end
                end
                default: ack_q <= 1'b0;
              endcase
            end
          end else if (scl_fall && (bitcnt == 4'd8)) begin
            bitcnt <= '0;
            if (miss_q) begin
              state <= ST_WAIT;
            end else begin
              state  <= ST_RACK;
              sda_oe <= ack_q;
            end
          end
        end
        ST_RACK: begin
          if (scl_fall) begin
            if (go_tx) begin
              tx_sh  <= cnt_val;
              sda_oe <= ~cnt_val[7];
              state  <= ST_TX;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 1'b1;
          end else if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              bitcnt <= '0;
              sda_oe <= 1'b0;
              state  <= ST_TACK;
            end else begin
              tx_sh  <= tx_sh << 1;
              sda_oe <= ~tx_sh[6];
            end
          end
        end
        ST_TACK: begin
          if (scl_rise && sda_f) begin
            state <= ST_WAIT;
          end else if (scl_fall) begin
            tx_sh  <= rd_data;
            sda_oe <= ~rd_data[7];
            ptr    <= ptr_nxt;
            state  <= ST_TX;
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = sda_oe;
endmodule

// File: rtl/smb_regbank_target_chk.sv
module smb_regbank_target_chk
  import smb_tgt_pkg::*;
#(
  parameter int AW = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_f,
  input logic       sda_f,
  input logic       sda_oe,
  input logic       scl_rise,
  input logic       ev_start,
  input logic       ev_stop,
  input logic       wr_stb,
  input logic [AW-1:0] ptr,
  input tgt_state_e state,
  input rx_phase_e  phase,
  input logic [3:0] bitcnt
);
  // R10: drive changes only while the filtered clock is low
  p_drive_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_f);

  // R9: stop returns to idle with the line released
  p_stop_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> (state == ST_IDLE) && !sda_oe);

  // R9: start restarts address reception from bit zero
  p_start_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> (state == ST_RX) && (phase == PH_ADDR) && (bitcnt == 4'd0));

  // R3: every stored data byte steps the index by one with wrap
  p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> ptr == AW'($past(ptr) + 1'b1));

  // R8: host NACK leaves the target parked with the line released
  p_nack_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_TACK) && scl_rise && sda_f && !ev_start && !ev_stop)
      |=> (state == ST_WAIT) && !sda_oe);
endmodule

bind smb_regbank_target smb_regbank_target_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f), .sda_oe(sda_oe),
  .scl_rise(scl_rise), .ev_start(ev_start), .ev_stop(ev_stop), .wr_stb(wr_stb),
  .ptr(ptr), .state(state), .phase(phase), .bitcnt(bitcnt)
);

// File: tb/smb_regbank_target_tb.sv
module smb_regbank_target_tb;
  localparam int CLK_P = 10;
  localparam int QT    = 10 * CLK_P;   // quarter SCL period
  localparam int WD_CY = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_host = 1'b1;
  logic sda_host = 1'b1;
  logic addr_sel = 1'b0;
  logic glitch_en = 1'b0;
  logic sda_oe;
  logic sda_line;

  int checks = 0;
  int errors = 0;
  int r10_viol = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  assign sda_line = sda_host & ~sda_oe;

  smb_regbank_target u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_host), .sda_i(sda_line),
    .addr_sel_i(addr_sel), .sda_oe_o(sda_oe)
  );

  // R10 monitor: the drive may only move while the host holds SCL low
  always @(sda_oe) if (rst_n && scl_host) r10_viol++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // ---- bit level host ----
  task automatic bus_start();
    sda_host = 1'b1; scl_host = 1'b1; #(QT);
    sda_host = 1'b0; #(2*QT);
    scl_host = 1'b0; #(QT);
  endtask

  task automatic bus_rstart();
    sda_host = 1'b1; #(QT);
    scl_host = 1'b1; #(QT);
    sda_host = 1'b0; #(QT);
    scl_host = 1'b0; #(QT);
  endtask

  task automatic bus_stop();
    sda_host = 1'b0; #(QT);
    scl_host = 1'b1; #(QT);
    sda_host = 1'b1; #(2*QT);
  endtask

  task automatic write_bit(input logic b);
    sda_host = b;
    if (glitch_en) begin
      #(QT/2); scl_host = 1'b1; #(CLK_P); scl_host = 1'b0; #(QT/2);
    end
    #(QT);
    scl_host = 1'b1; #(2*QT);
    scl_host = 1'b0; #(QT);
  endtask

  task automatic read_bit(output logic b);
    sda_host = 1'b1; #(QT);
    scl_host = 1'b1; #(QT);
    b = sda_line; #(QT);
    scl_host = 1'b0; #(QT);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) write_bit(v[i]);
    read_bit(a);
    ack = ~a;
  endtask

  task automatic recv_byte(input logic host_ack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      read_bit(b);
      v[i] = b;
    end
    write_bit(~host_ack);
  endtask

  // ---- transaction level ----
  task automatic do_write(input logic [7:0] dev, input logic [7:0] idx, input logic [7:0] cnt,
                          input int n, input logic [7:0] d [8], output logic [11:0] acks);
    logic a;
    acks = '0;
    bus_start();
    send_byte(dev, a); acks[0] = a;
    send_byte(idx, a); acks[1] = a;
    send_byte(cnt, a); acks[2] = a;
    for (int i = 0; i < n; i++) begin
      send_byte(d[i], a); acks[3+i] = a;
    end
    bus_stop();
  endtask

  task automatic do_read(input logic [7:0] dev, input logic [7:0] idx, input int n,
                         output logic [7:0] cnt_b, output logic [7:0] d [8]);
    logic a;
    bus_start();
    send_byte(dev, a);
    send_byte(idx, a);
    bus_rstart();
    send_byte(dev | 8'h01, a);
    recv_byte(1'b1, cnt_b);
    for (int i = 0; i < n; i++) recv_byte(i != n - 1, d[i]);
    bus_stop();
  endtask

  // ---- scenarios ----
  logic [7:0] wd [8];
  logic [7:0] rd [8];
  logic [7:0] cb;
  logic [11:0] ak;

  task automatic t_reset();
    chk(sda_oe == 1'b0, "R11 sda released", int'(sda_oe), 0);
    do_read(8'hDC, 8'd14, 3, cb, rd);
    chk(cb == 8'h08, "R11/R5 count reset", cb, 8'h08);
    chk(rd[0] == 8'h00, "R6 reserved reads zero", rd[0], 0);
    chk(rd[1] == 8'hA5, "R11 id register", rd[1], 8'hA5);
    chk(rd[2] == 8'h00, "R3 read wraps to reg0", rd[2], 0);
  endtask

  task automatic t_write_run();
    wd[0] = 8'h11; wd[1] = 8'h22; wd[2] = 8'h33; wd[3] = 8'h44;
    do_write(8'hDC, 8'd2, 8'd4, 4, wd, ak);
    chk(ak[6:0] == 7'h7F, "R2 every byte acked", ak[6:0], 7'h7F);
    do_read(8'hDC, 8'd2, 4, cb, rd);
    chk(rd[0] == 8'h11 && rd[1] == 8'h22, "R4 read N,N+1", {rd[0], rd[1]}, 16'h1122);
    chk(rd[2] == 8'h33 && rd[3] == 8'h44, "R2 stored N+2,N+3", {rd[2], rd[3]}, 16'h3344);
  endtask

  task automatic t_wrap();
    wd[0] = 8'h5A; wd[1] = 8'h5B; wd[2] = 8'hC1; wd[3] = 8'hC2;
    do_write(8'hDC, 8'd14, 8'd4, 4, wd, ak);
    chk(ak[6:0] == 7'h7F, "R6 read-only writes acked", ak[6:0], 7'h7F);
    do_read(8'hDC, 8'd14, 4, cb, rd);
    chk(rd[0] == 8'h00 && rd[1] == 8'hA5, "R6 writes discarded", {rd[0], rd[1]}, 16'h00A5);
    chk(rd[2] == 8'hC1 && rd[3] == 8'hC2, "R3 write wrapped", {rd[2], rd[3]}, 16'hC1C2);
  endtask

  task automatic t_excess();
    wd[0] = 8'h77; wd[1] = 8'h99;
    do_write(8'hDC, 8'd4, 8'd1, 2, wd, ak);
    chk(ak[3] == 1'b1, "R7 counted byte acked", ak[3], 1);
    chk(ak[4] == 1'b0, "R7 extra byte nacked", ak[4], 0);
    do_read(8'hDC, 8'd4, 2, cb, rd);
    chk(rd[0] == 8'h77 && rd[1] == 8'h44, "R7 extra not stored", {rd[0], rd[1]}, 16'h7744);
  endtask

  task automatic t_addr();
    wd[0] = 8'h66;
    do_write(8'hDE, 8'd9, 8'd1, 1, wd, ak);
    chk(ak[0] == 1'b0, "R1 alt address nacked with sel low", ak[0], 0);
    addr_sel = 1'b1;
    do_write(8'hDC, 8'd9, 8'd1, 1, wd, ak);
    chk(ak[0] == 1'b0, "R1 base address nacked with sel high", ak[0], 0);
    do_write(8'hDE, 8'd9, 8'd1, 1, wd, ak);
    chk(ak[3:0] == 4'hF, "R1 alt address acked", ak[3:0], 4'hF);
    do_read(8'hDE, 8'd9, 1, cb, rd);
    chk(rd[0] == 8'h66, "R1 alt read back", rd[0], 8'h66);
    addr_sel = 1'b0;
  endtask

  task automatic t_count();
    wd[0] = 8'h03;
    do_write(8'hDC, 8'd8, 8'd1, 1, wd, ak);
    do_read(8'hDC, 8'd0, 1, cb, rd);
    chk(cb == 8'h03, "R5 count from reg8", cb, 8'h03);
    wd[0] = 8'h08;
    do_write(8'hDC, 8'd8, 8'd1, 1, wd, ak);
  endtask

  task automatic t_nack();
    logic a, b;
    bus_start();
    send_byte(8'hDC, a);
    send_byte(8'd2, a);
    bus_rstart();
    send_byte(8'hDD, a);
    recv_byte(1'b1, cb);
    recv_byte(1'b0, cb);
    chk(cb == 8'h11, "R4 first data byte", cb, 8'h11);
    read_bit(b);
    chk(b == 1'b1, "R8 line released after nack", b, 1);
    read_bit(b);
    chk(b == 1'b1 && sda_oe == 1'b0, "R8 still released", b, 1);
    bus_stop();
  endtask

  task automatic t_abort();
    logic a;
    bus_start();
    send_byte(8'hDC, a);
    send_byte(8'd6, a);
    send_byte(8'd2, a);
    send_byte(8'hAB, a);
    for (int i = 7; i >= 4; i--) write_bit(i[0]);
    bus_stop();
    chk(sda_oe == 1'b0, "R9 released after stop", sda_oe, 0);
    do_read(8'hDC, 8'd6, 2, cb, rd);
    chk(rd[0] == 8'hAB, "R9 completed byte kept", rd[0], 8'hAB);
    chk(rd[1] == 8'h00, "R9 partial byte dropped", rd[1], 0);
  endtask

  task automatic t_glitch();
    wd[0] = 8'h3C; wd[1] = 8'hC3;
    glitch_en = 1'b1;
    do_write(8'hDC, 8'd12, 8'd2, 2, wd, ak);
    glitch_en = 1'b0;
    chk(ak[4:0] == 5'h1F, "R12 acks with glitches", ak[4:0], 5'h1F);
    do_read(8'hDC, 8'd12, 2, cb, rd);
    chk(rd[0] == 8'h3C && rd[1] == 8'hC3, "R12 data intact", {rd[0], rd[1]}, 16'h3CC3);
  endtask

  initial begin
    #(WD_CY * CLK_P);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(5 * CLK_P);
    rst_n = 1'b1;
    #(5 * CLK_P);
    t_reset();
    t_write_run();
    t_wrap();
    t_excess();
    t_addr();
    t_count();
    t_nack();
    t_abort();
    t_glitch();
    chk(r10_viol == 0, "R10 drive moved with SCL high", r10_viol, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule